// File: doc/BRIEF.md
# Twin-Ball Bitmap Render Controller

This block paints two small balls into a pixel bitmap through its write port. It has one sprite sequencer. That sequencer turns a top-left anchor into a fixed run of pixel coordinates, one coordinate per cycle. A small state machine shares the sequencer between the two balls. It arms the sequencer with the first anchor and waits for the sequencer's last-pixel flag. It then arms the sequencer again with the second anchor. Each ball is written in its own 3-bit colour. After both balls are painted, the controller stops and stays quiet until the next reset.

The bitmap write port carries a 9-bit column, an 8-bit row, a 3-bit colour and a write enable. The column and row come directly from the sequencer. Four paddle button inputs are present on the port list but have no function in this block.

Each ball is a five-pixel plus shape. The pixels are emitted in this order, as (column, row) offsets from the anchor: (1,0), (0,1), (1,1), (2,1), (1,2).

Top module: `twin_ball_render`

## Requirements
- R1: While reset is high, and in the first cycle after reset falls, the write enable is low.
- R2: The first pixel of ball 0 is presented in the second cycle after reset falls, at anchor (100,50) plus offset (1,0).
- R3: Each ball is written as five pixels on five consecutive cycles, in the offset order (1,0), (0,1), (1,1), (2,1), (1,2) from its anchor.
- R4: Ball 0 is written with colour code 3'b100 and ball 1 with colour code 3'b010. The colour does not change within a ball.
- R5: Ball 1 is armed only after the last pixel of ball 0. Exactly one cycle with write enable low separates the two balls. Ball 1 is anchored at (200,120).
- R6: After the tenth pixel, the write enable stays low until reset.
- R7: When the sequence ends, the bitmap holds exactly ten written pixels. Each pixel holds the colour of its own ball.
- R8: The four paddle inputs have no effect on any output.
- R9: A reset asserted in the middle of drawing restarts the whole sequence from ball 0.
- R10: The sequencer start is high for exactly one cycle per ball, and only while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_l_up | input | 1 | Left paddle up button (unused) |
| pad_l_dn | input | 1 | Left paddle down button (unused) |
| pad_r_up | input | 1 | Right paddle up button (unused) |
| pad_r_dn | input | 1 | Right paddle down button (unused) |
| vga_x | output | 9 | Bitmap column of the pixel to write |
| vga_y | output | 8 | Bitmap row of the pixel to write |
| vga_color | output | 3 | Colour code of the pixel to write |
| vga_wr_en | output | 1 | High on cycles that carry a valid pixel |

## Verification
Two events fall in the same cycle: the sequencer's last pixel of ball 0, and the controller's decision to leave the first ball. The final pixel must still carry ball 0's colour and be written. The hand-off may only take effect at the next edge. The bench follows the full draw with a per-cycle reference and checks four things at that boundary. The fifth pixel is enabled in colour 3'b100. The next cycle is a single idle gap. Ball 1 opens with colour 3'b010. A reset landing inside ball 1 must also return the sequence cleanly to ball 0.

// File: rtl/twin_ball_render.sv
module sprite_seq #(
  parameter int XW = 9,
  parameter int YW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  output logic [XW-1:0] x_out,
  output logic [YW-1:0] y_out,
  output logic          valid,
  output logic          done
);
  localparam int NPIX = 5;
  localparam int IW = $clog2(NPIX);
  localparam logic [IW-1:0] LAST = IW'(NPIX - 1);

  logic          active;
  logic [IW-1:0] idx;
  logic [XW-1:0] ax;
  logic [YW-1:0] ay;
  logic [1:0]    dx, dy;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      idx    <= '0;
      ax     <= x_in;
      ay     <= y_in;
    end else if (active) begin
      if (idx == LAST) active <= 1'b0;
      else idx <= idx + 1'b1;
    end
  end

  always_comb begin
    case (idx)
      IW'(0):  begin dx = 2'd1; dy = 2'd0; end
      IW'(1):  begin dx = 2'd0; dy = 2'd1; end
      IW'(2):  begin dx = 2'd1; dy = 2'd1; end
      IW'(3):  begin dx = 2'd2; dy = 2'd1; end
      default: begin dx = 2'd1; dy = 2'd2; end
    endcase
  end

  assign x_out = ax + XW'(dx);
  assign y_out = ay + YW'(dy);
  assign valid = active;
  assign done  = active && (idx == LAST);
endmodule

module twin_ball_render #(
  parameter int          XW  = 9,
  parameter int          YW  = 8,
  parameter int          CW  = 3,
  parameter logic [XW-1:0] BX0 = 9'd100,
  parameter logic [YW-1:0] BY0 = 8'd50,
  parameter logic [XW-1:0] BX1 = 9'd200,
  parameter logic [YW-1:0] BY1 = 8'd120,
  parameter logic [CW-1:0] COL0 = 3'b100,
  parameter logic [CW-1:0] COL1 = 3'b010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pad_l_up,
  input  logic          pad_l_dn,
  input  logic          pad_r_up,
  input  logic          pad_r_dn,
  output logic [XW-1:0] vga_x,
  output logic [YW-1:0] vga_y,
  output logic [CW-1:0] vga_color,
  output logic          vga_wr_en
);
  typedef enum logic [2:0] {ST_ARM0, ST_DRAW0, ST_ARM1, ST_DRAW1, ST_HALT} state_t;

  state_t        state;
  logic          seq_start, seq_done, finished;
  logic [XW-1:0] anchor_x;
  logic [YW-1:0] anchor_y;
  logic          unused_pads;

  assign unused_pads = ^{pad_l_up, pad_l_dn, pad_r_up, pad_r_dn};

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ARM0;
    else begin
      case (state)
        ST_ARM0:  state <= ST_DRAW0;
        ST_DRAW0: if (seq_done) state <= ST_ARM1;
        ST_ARM1:  state <= ST_DRAW1;
        ST_DRAW1: if (seq_done) state <= ST_HALT;
        default:  state <= ST_HALT;
      endcase
    end
  end

  assign seq_start = (state == ST_ARM0) || (state == ST_ARM1);
  assign anchor_x  = (state == ST_ARM0) ? BX0 : BX1;
  assign anchor_y  = (state == ST_ARM0) ? BY0 : BY1;
  assign vga_color = (state == ST_DRAW0) ? COL0 : COL1;
  assign finished  = (state == ST_HALT);

  sprite_seq #(.XW(XW), .YW(YW)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (seq_start),
    .x_in  (anchor_x),
    .y_in  (anchor_y),
    .x_out (vga_x),
    .y_out (vga_y),
    .valid (vga_wr_en),
    .done  (seq_done)
  );
endmodule

// File: rtl/twin_ball_render_chk.sv
module twin_ball_render_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          wr_en,
  input logic [CW-1:0] color,
  input logic          finished
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !wr_en);
  // R10
  start_single_chk: assert property (@(posedge clk) disable iff (rst) start |=> !start);
  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (rst) start |-> !wr_en);
  // R3
  pixel_run_chk: assert property (@(posedge clk) disable iff (rst) (wr_en && !done) |=> wr_en);
  // R4
  colour_hold_chk: assert property (@(posedge clk) disable iff (rst) (wr_en && !done) |=> $stable(color));
  // R5
  handoff_gap_chk: assert property (@(posedge clk) disable iff (rst) done |=> !wr_en);
  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst) finished |-> !wr_en);
endmodule

bind twin_ball_render twin_ball_render_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (seq_start),
  .done     (seq_done),
  .wr_en    (vga_wr_en),
  .color    (vga_color),
  .finished (finished)
);

// File: tb/twin_ball_render_test.sv
module twin_ball_render_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pl_u = 0, pl_d = 0, pr_u = 0, pr_d = 0;
  logic [8:0] vx;
  logic [7:0] vy;
  logic [2:0] vc;
  logic       we;
  int checks = 0, errors = 0;
  int cyc = 0;
  logic [2:0] bitmap [int];
  int dxs [5] = '{1, 0, 1, 2, 1};
  int dys [5] = '{0, 1, 1, 1, 2};

  always #5 clk = ~clk;

  twin_ball_render uut (
    .clk(clk), .rst(rst),
    .pad_l_up(pl_u), .pad_l_dn(pl_d), .pad_r_up(pr_u), .pad_r_dn(pr_d),
    .vga_x(vx), .vga_y(vy), .vga_color(vc), .vga_wr_en(we)
  );

  always @(negedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (we) bitmap[int'(vy) * 512 + int'(vx)] = vc;
  end

  function automatic void expect_at(input int n, output bit e, output int x, output int y, output int c);
    e = 0; x = 0; y = 0; c = 0;
    if (n >= 1 && n <= 5) begin
      e = 1; x = 100 + dxs[n-1]; y = 50 + dys[n-1]; c = 4;
    end else if (n >= 7 && n <= 11) begin
      e = 1; x = 200 + dxs[n-7]; y = 120 + dys[n-7]; c = 2;
    end
  endfunction

  function automatic string tag_of(input int n);
    if (n == 0) return "R1";
    if (n == 1) return "R2";
    if (n == 6) return "R5";
    if (n >= 12) return "R6";
    return "R3";
  endfunction

  task automatic hold_reset(input int k);
    rst = 1'b1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      checks++;
      if (we !== 1'b0) begin
        errors++;
        $display("FAIL R1: wr_en during reset actual %b expected 0", we);
      end
    end
    rst = 1'b0;
  endtask

  task automatic run(input int ncyc, input bit toggle_pads);
    bit e; int x, y, c;
    for (int n = 0; n < ncyc; n++) begin
      if (n > 0) @(negedge clk);
      if (toggle_pads) begin
        pl_u = n[0]; pl_d = n[1]; pr_u = n[2]; pr_d = ~n[0];
      end
      expect_at(n, e, x, y, c);
      checks++;
      if (we !== e) begin
        errors++;
        $display("FAIL %s%s: cycle %0d wr_en actual %b expected %b", tag_of(n), toggle_pads ? "/R8" : "", n, we, e);
      end else if (e) begin
        checks++;
        if (int'(vx) != x || int'(vy) != y) begin
          errors++;
          $display("FAIL %s%s: cycle %0d pixel actual (%0d,%0d) expected (%0d,%0d)", tag_of(n), toggle_pads ? "/R8" : "", n, vx, vy, x, y);
        end
        checks++;
        if (int'(vc) != c) begin
          errors++;
          $display("FAIL R4: cycle %0d colour actual %0d expected %0d", n, vc, c);
        end
      end
    end
  endtask

  task automatic check_bitmap();
    checks++;
    if (bitmap.num() != 10) begin
      errors++;
      $display("FAIL R7: bitmap pixel count actual %0d expected 10", bitmap.num());
    end
    for (int i = 0; i < 5; i++) begin
      int k0 = (50 + dys[i]) * 512 + 100 + dxs[i];
      int k1 = (120 + dys[i]) * 512 + 200 + dxs[i];
      checks++;
      if (!bitmap.exists(k0) || bitmap[k0] != 3'b100) begin
        errors++;
        $display("FAIL R7: ball0 pixel %0d actual %0d expected 4", i, bitmap.exists(k0) ? int'(bitmap[k0]) : -1);
      end
      checks++;
      if (!bitmap.exists(k1) || bitmap[k1] != 3'b010) begin
        errors++;
        $display("FAIL R7: ball1 pixel %0d actual %0d expected 2", i, bitmap.exists(k1) ? int'(bitmap[k1]) : -1);
      end
    end
  endtask

  initial begin
    // R1 R2 R3 R4 R5 R6: plain run
    @(negedge clk);
    hold_reset(3);
    run(30, 1'b0);
    // R7
    check_bitmap();
    // R9: reset inside ball 1, then a clean restart
    hold_reset(2);
    run(9, 1'b0);
    hold_reset(2);
    run(30, 1'b0);
    check_bitmap();
    // R8: paddles toggling for a whole sequence
    hold_reset(2);
    run(30, 1'b1);
    check_bitmap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule